// File: doc/BRIEF.md
# Lag Integrator Bank with Held Readout

This block accumulates the carry pulses produced by a bank of correlator lag stages, one accumulator per lag. A carry has weight one in a lane's count. The low-order part of each count is thrown away by a prescaler: a short counter that passes one increment to the kept counter each time it wraps. Its length is either the long setting or a short setting chosen with an input pin. The short setting gives four times finer resolution and four times less integration range before the kept counter fills. The kept counter is a synchronous saturating counter. Once it reaches all ones it stays there and never wraps.

A transfer strobe copies the kept count of every lane into a per-lag holding store in one clock edge. The same edge starts a new integration, so the stored words can be read through an address/data port while the counters keep running. The read is combinational and the stored words change only at the next transfer. A separate start input discards the integration in progress without touching the store. The short-integration option should be changed only on the cycle after a transfer or start.

Top module: `integ_bank`

## Requirements
- R1: Each cycle in which a lane's carry input is high (and neither start nor transfer is high) adds one to that lane's raw count. A cycle with the carry low leaves the lane unchanged.
- R2: With short_i low, the word stored for a lane is floor(N / 16), where N is the number of carries counted since the integration began (the prescaler is 4 bits long).
- R3: With short_i high, the stored word is floor(N / 4) (the prescaler is 2 bits long).
- R4: The kept count saturates at all ones (2^OUT_W - 1) and stays there while further carries arrive.
- R5: A clock edge with xfer_i high loads every lane's kept count, as it was before that edge, into the store. From that edge on, rd_data_o shows the word of lane rd_addr_i combinationally. The stored words do not change until the next transfer.
- R6: The transfer edge also restarts every lane's integration. A carry that is high in the transfer cycle is counted as the first carry of the new integration.
- R7: A clock edge with start_i high clears every lane's count and drops that cycle's carry. The store is left unchanged. If xfer_i is high in the same cycle, the store still loads.
- R8: While rst_n is low at a clock edge, all counts and all stored words become zero.
- R9: Lanes are independent: the carries of one lane never change the word of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Discard the running integration |
| xfer_i | input | 1 | Copy kept counts to the store and restart |
| short_i | input | 1 | Select the short prescaler |
| carry_i | input | NLAG | One carry pulse input per lag |
| rd_addr_i | input | clog2(NLAG) | Lag index to read |
| rd_data_o | output | OUT_W | Stored word of the addressed lag |

## Verification
Counts change at the edge where a carry is sampled, but they are seen only through the store. The store is loaded at the transfer edge, and rd_data_o is valid for the new word right after that same edge, with no further register. The bench changes inputs just after a rising edge and applies them at the next one. After each transfer it sets the read address at a falling edge and samples the data a time unit later. Expected words come from per-lane carry tallies shifted by the prescaler length and clipped at the maximum, all computed in the bench. A narrow configuration makes saturation reachable within a short run.

// File: rtl/integ_pkg.sv
// Shared defaults for the lag integrator bank.
// Assumes: the short prescaler is at least one bit and no longer than the long one.
package integ_pkg;
    localparam int unsigned DEF_NLAG      = 16;
    localparam int unsigned DEF_OUT_W     = 16;
    localparam int unsigned DEF_PRE_LONG  = 4;
    localparam int unsigned DEF_PRE_SHORT = 2;
endpackage

// File: rtl/integ_lane.sv
// One lane: a selectable-length prescaler feeding a saturating kept counter.
// Assumes: short_i is stable within an integration; clear_i has priority over restart_i.
module integ_lane #(
    parameter int unsigned PRE_LONG  = integ_pkg::DEF_PRE_LONG,
    parameter int unsigned PRE_SHORT = integ_pkg::DEF_PRE_SHORT,
    parameter int unsigned OUT_W     = integ_pkg::DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             restart_i,
    input  logic             carry_i,
    input  logic             short_i,
    output logic [OUT_W-1:0] kept_o
);
    localparam logic [PRE_LONG-1:0] LIM_LONG  = PRE_LONG'((64'd1 << PRE_LONG) - 64'd1);
    localparam logic [PRE_LONG-1:0] LIM_SHORT = PRE_LONG'((64'd1 << PRE_SHORT) - 64'd1);
    localparam logic [OUT_W-1:0]    KEPT_MAX  = '1;

    logic [PRE_LONG-1:0] pre_q;
    logic [OUT_W-1:0]    kept_q;
    logic [PRE_LONG-1:0] pre_lim;
    logic                wrap;

    // Pick the prescaler terminal value and detect a wrap on this carry.
    always_comb begin
        pre_lim = short_i ? LIM_SHORT : LIM_LONG;
        wrap    = carry_i && (pre_q >= pre_lim);
    end

    // Advance the prescaler and pass wraps into the saturating kept counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre_q  <= '0;
            kept_q <= '0;
        end else if (restart_i) begin
            pre_q  <= carry_i ? PRE_LONG'(1) : '0;
            kept_q <= '0;
        end else if (carry_i) begin
            if (wrap) begin
                pre_q  <= '0;
                kept_q <= (kept_q == KEPT_MAX) ? kept_q : kept_q + OUT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_LONG'(1);
            end
        end
    end

    assign kept_o = kept_q;
endmodule

// File: rtl/integ_store.sv
// Per-lag holding store: loads all lanes at once, read combinationally by index.
// Assumes: an address at or beyond NLAG reads as zero.
module integ_store #(
    parameter int unsigned NLAG  = integ_pkg::DEF_NLAG,
    parameter int unsigned OUT_W = integ_pkg::DEF_OUT_W,
    parameter int unsigned AW    = (NLAG > 1) ? $clog2(NLAG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [NLAG-1:0][OUT_W-1:0]  wr_i,
    input  logic [AW-1:0]               rd_addr_i,
    output logic [OUT_W-1:0]            rd_data_o,
    output logic [NLAG-1:0][OUT_W-1:0]  words_o
);
    logic [NLAG-1:0][OUT_W-1:0] words_q;

    // Capture every lane's word on a load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (load_i) begin
            words_q <= wr_i;
        end
    end

    // Select the addressed word without a register stage.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NLAG; k++) begin
            if (32'(rd_addr_i) == k) rd_data_o = words_q[k];
        end
    end

    assign words_o = words_q;
endmodule

// File: rtl/integ_bank.sv
// Bank of lag integrators with a held readout store.
// Assumes: start_i and xfer_i are single-cycle strobes; short_i changes only after a restart.
module integ_bank #(
    parameter int unsigned NLAG      = integ_pkg::DEF_NLAG,
    parameter int unsigned OUT_W     = integ_pkg::DEF_OUT_W,
    parameter int unsigned PRE_LONG  = integ_pkg::DEF_PRE_LONG,
    parameter int unsigned PRE_SHORT = integ_pkg::DEF_PRE_SHORT,
    parameter int unsigned AW        = (NLAG > 1) ? $clog2(NLAG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             xfer_i,
    input  logic             short_i,
    input  logic [NLAG-1:0]  carry_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [OUT_W-1:0] rd_data_o
);
    logic [NLAG-1:0][OUT_W-1:0] main_q;
    logic [NLAG-1:0][OUT_W-1:0] store_q;

    for (genvar g = 0; g < NLAG; g++) begin : g_lane
        integ_lane #(
            .PRE_LONG (PRE_LONG),
            .PRE_SHORT(PRE_SHORT),
            .OUT_W    (OUT_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (start_i),
            .restart_i(xfer_i),
            .carry_i  (carry_i[g]),
            .short_i  (short_i),
            .kept_o   (main_q[g])
        );
    end

    integ_store #(
        .NLAG (NLAG),
        .OUT_W(OUT_W),
        .AW   (AW)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (xfer_i),
        .wr_i     (main_q),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o),
        .words_o  (store_q)
    );
endmodule

// File: rtl/integ_bank_chk.sv
// Property checker for integ_bank, attached by bind below.
// Assumes: sees the kept counts and the stored words of the bank.
module integ_bank_chk #(
    parameter int unsigned NLAG  = integ_pkg::DEF_NLAG,
    parameter int unsigned OUT_W = integ_pkg::DEF_OUT_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       xfer_i,
    input logic [NLAG-1:0]            carry_i,
    input logic [NLAG-1:0][OUT_W-1:0] main_q,
    input logic [NLAG-1:0][OUT_W-1:0] store_q
);
    for (genvar g = 0; g < NLAG; g++) begin : g_chk
        p_quiet_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!carry_i[g] && !start_i && !xfer_i) |=> $stable(main_q[g]));
        p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_i && !xfer_i) |=> (OUT_W'(main_q[g] - $past(main_q[g])) <= OUT_W'(1)));
        p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((&main_q[g]) && !start_i && !xfer_i) |=> (&main_q[g]));
        p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_i |=> (store_q[g] == $past(main_q[g])));
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer_i |=> $stable(store_q[g]));
        p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_i |=> (main_q[g] == '0));
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> (main_q[g] == '0));
    end
endmodule

bind integ_bank integ_bank_chk #(
    .NLAG (NLAG),
    .OUT_W(OUT_W)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .xfer_i (xfer_i),
    .carry_i(carry_i),
    .main_q (main_q),
    .store_q(store_q)
);

// File: tb/test_integ_bank.sv
module test_integ_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 4;
    localparam int OW  = 6;
    localparam int AWB = 2;
    localparam int MAXV = (1 << OW) - 1;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          start = 0;
    logic          xfer = 0;
    logic          short_m = 0;
    logic [NL-1:0] carry = '0;
    logic [AWB-1:0] rd_addr = '0;
    logic [OW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cnt[NL];
    int exp_st[NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    integ_bank #(.NLAG(NL), .OUT_W(OW), .PRE_LONG(4), .PRE_SHORT(2)) i_integ_bank (
        .clk(clk), .rst_n(rst_n), .start_i(start), .xfer_i(xfer), .short_i(short_m),
        .carry_i(carry), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    function automatic int kept(input int n, input logic s);
        int v;
        v = s ? (n >> 2) : (n >> 4);
        return (v > MAXV) ? MAXV : v;
    endfunction

    // One clock: apply inputs, update the bench model at the edge, release inputs.
    task automatic step(input logic [NL-1:0] c, input logic x, input logic s);
        @(negedge clk);
        carry = c; xfer = x; start = s;
        @(posedge clk);
        for (int i = 0; i < NL; i++) begin
            if (x) exp_st[i] = kept(cnt[i], short_m);
            if (s) cnt[i] = 0;
            else if (x) cnt[i] = c[i] ? 1 : 0;
            else if (c[i]) cnt[i] = cnt[i] + 1;
        end
        #1;
        carry = '0; xfer = 0; start = 0;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NL; i++) begin
            @(negedge clk);
            rd_addr = AWB'(i);
            #1;
            n_chk++;
            if (rd_data !== OW'(exp_st[i])) begin
                n_bad++;
                $display("FAIL %s lane %0d actual=%0d expected=%0d", req, i, rd_data, exp_st[i]);
            end
        end
    endtask

    // Lane i gets a carry in the first len[i] of 'total' cycles, then a transfer.
    task automatic run_counts(input int l0, input int l1, input int l2, input int l3, input int total);
        int len[NL];
        logic [NL-1:0] c;
        len[0] = l0; len[1] = l1; len[2] = l2; len[3] = l3;
        for (int t = 0; t < total; t++) begin
            for (int i = 0; i < NL; i++) c[i] = (t < len[i]);
            step(c, 0, 0);
        end
        step('0, 1, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++; n_chk++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin cnt[i] = 0; exp_st[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R8: store is zero out of reset
        check_all("R8");

        // R2, R9: boundaries around one prescaler wrap, long mode
        run_counts(15, 16, 17, 31, 40);
        check_all("R2");
        run_counts(0, 47, 48, 100, 120);
        check_all("R2_R9");

        // R5: counters run without a transfer; store holds
        for (int t = 0; t < 50; t++) step('1, 0, 0);
        check_all("R5");

        // R6: carry in the transfer cycle starts the new count
        step('0, 1, 0);
        step('1, 1, 0);
        for (int t = 0; t < 15; t++) step(4'b0101, 0, 0);
        step('0, 1, 0);
        check_all("R6");

        // R3: short prescaler sweep
        short_m = 1;
        step('0, 1, 0);
        for (int n = 0; n < 12; n++) begin
            run_counts(3*n, 3*n + 1, 3*n + 2, 3*n + 3, 40);
            check_all("R3");
        end
        short_m = 0;
        step('0, 1, 0);

        // R4: saturation and the edge just below it, long mode
        run_counts(1100, 1007, 1008, 1023, 1100);
        check_all("R4");

        // R7: start discards the count, store untouched, carry dropped
        for (int t = 0; t < 40; t++) step('1, 0, 0);
        step('1, 0, 1);
        check_all("R7");
        for (int t = 0; t < 15; t++) step('1, 0, 0);
        step('0, 1, 0);
        check_all("R7_R1");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule